// File: doc/BRIEF.md
# Single-Port Writeback Scheduler

This block arbitrates the one write port of a register file in a short in-order pipeline where two instruction classes retire at different depths. Loads reach the register file in their fifth stage. Register-to-register ALU operations finish their work one stage earlier. Each cycle the block is offered one instruction class (load, ALU, or nothing), a destination register and the result value. It carries each accepted instruction down a chain of stage registers and drives a single register-file write.

Two retirement policies are available, and the choice is latched while reset is held. Under the early policy an ALU result is written in stage four. When that write would land in the same cycle as the write of the load accepted one cycle before it, the block raises a fetch stall. The ALU instruction is then not taken that cycle, and an empty slot travels down the pipe in its place. Under the uniform policy every ALU result passes through the idle memory stage and is written in stage five, like a load. The two writes can then never meet, and no stall is needed.

Top module: `wb_port_sched`

## Requirements
- R1: A load accepted in cycle n (offered with kind code 2'b10 while fetch stall is low) drives a register-file write in cycle n+4 with its destination and data, under either policy.
- R2: At most one register-file write occurs per cycle, and the write port never has two candidates in the same cycle.
- R3: Under the early policy, an ALU instruction (kind 2'b01) accepted in cycle n is written in cycle n+3.
- R4: Under the early policy, an ALU instruction offered in the cycle right after a load was accepted raises fetch stall and is not accepted that cycle. Held on the input, it is accepted in the next cycle. A stall never lasts two cycles in a row, and only an offered ALU instruction can raise it.
- R5: Under the uniform policy, an ALU instruction accepted in cycle n is written in cycle n+4, and fetch stall is never raised.
- R6: An accepted instruction whose destination is register 0 produces no write.
- R7: The policy input is sampled only while reset is asserted (1 selects the uniform policy). Changes to it after reset have no effect on stalls or write timing.
- R8: Register writes occur in the order the instructions were accepted.
- R9: During reset and while only kind 2'b00 or 2'b11 is offered, nothing is written and no stall is raised. An empty slot never writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| late_wb_i | input | 1 | Policy select, latched during reset: 1 uniform stage-five writeback, 0 early ALU writeback with stall |
| iss_kind_i | input | 2 | Offered instruction class: 00 none, 01 ALU, 10 load, 11 none |
| iss_rd_i | input | 5 | Destination register of the offered instruction |
| iss_data_i | input | 32 | Result value carried with the offered instruction |
| fetch_stall_o | output | 1 | Offered instruction not accepted this cycle; hold it |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | 32 | Register-file write data |

## Verification
The fetch stall is combinational from the offered class and the pipe state, so it is judged in the cycle the instruction is offered. A write is due three cycles after acceptance for an early ALU instruction, and four cycles after for a load or a uniform-policy ALU instruction. The bench model notes each acceptance at its cycle number and books the write into the slot for the cycle it is due. Outputs are then compared each cycle between edges, so every write is judged in exactly the cycle it belongs to. A wrong cycle shows up both as a missing write and as an unexpected one.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
    parameter int REG_AW = 5;
    parameter int DATA_W = 32;

    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_ALU  = 2'b01,
        KIND_LOAD = 2'b10,
        KIND_RSVD = 2'b11
    } kind_e;

    // One pipeline slot; vld = 0 marks an empty slot (bubble)
    typedef struct packed {
        logic              vld;
        logic              is_load;
        logic [REG_AW-1:0] rd;
        logic [DATA_W-1:0] data;
    } slot_t;
endpackage

// File: rtl/wbs_hazard.sv
module wbs_hazard
    import wbs_pkg::*;
(
    input  logic  late_i,
    input  kind_e kind_i,
    input  slot_t peer_i,     // slot whose writeback lands with an ALU offered now
    output logic  stall_o
);
    always_comb begin
        stall_o = !late_i && (kind_i == KIND_ALU) && peer_i.vld && peer_i.is_load;
    end
endmodule

// File: rtl/wbs_wb_select.sv
module wbs_wb_select
    import wbs_pkg::*;
(
    input  logic              late_i,
    input  slot_t             early_i,   // slot in the early ALU writeback stage
    input  slot_t             final_i,   // slot in the last stage
    output logic              we_o,
    output logic [REG_AW-1:0] waddr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              clash_o
);
    logic early_hit, final_hit;
    slot_t pick;

    always_comb begin
        early_hit = !late_i && early_i.vld && !early_i.is_load;
        final_hit = final_i.vld && (final_i.is_load || late_i);
        clash_o   = early_hit && final_hit;
        pick      = early_hit ? early_i : final_i;
        we_o      = (early_hit || final_hit) && (pick.rd != '0);
        waddr_o   = pick.rd;
        wdata_o   = pick.data;
    end
endmodule

// File: rtl/wb_port_sched.sv
module wb_port_sched
    import wbs_pkg::*;
#(
    parameter int NSTAGE = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              late_wb_i,
    input  logic [1:0]        iss_kind_i,
    input  logic [REG_AW-1:0] iss_rd_i,
    input  logic [DATA_W-1:0] iss_data_i,
    output logic              fetch_stall_o,
    output logic              rf_we_o,
    output logic [REG_AW-1:0] rf_waddr_o,
    output logic [DATA_W-1:0] rf_wdata_o
);
    // stg[i] holds the instruction in stage i+2
    localparam int NREG      = NSTAGE - 1;
    localparam int EARLY_IDX = NREG - 2;          // stage NSTAGE-1
    localparam int FINAL_IDX = NREG - 1;          // stage NSTAGE
    localparam int GAP       = FINAL_IDX - EARLY_IDX;
    localparam int PEER_IDX  = GAP - 1;

    typedef struct packed {
        logic                 late;
        slot_t [NREG-1:0]     stg;
    } state_t;

    state_t st_d, st_q;
    kind_e  kind;
    logic   stall;
    logic   wb_clash;

    assign kind = kind_e'(iss_kind_i);

    wbs_hazard u_hazard (
        .late_i  (st_q.late),
        .kind_i  (kind),
        .peer_i  (st_q.stg[PEER_IDX]),
        .stall_o (stall)
    );

    wbs_wb_select u_wbsel (
        .late_i  (st_q.late),
        .early_i (st_q.stg[EARLY_IDX]),
        .final_i (st_q.stg[FINAL_IDX]),
        .we_o    (rf_we_o),
        .waddr_o (rf_waddr_o),
        .wdata_o (rf_wdata_o),
        .clash_o (wb_clash)
    );

    assign fetch_stall_o = stall;

    always_comb begin
        st_d = st_q;
        for (int i = NREG - 1; i > 0; i--) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
        st_d.stg[0].vld     = ((kind == KIND_ALU) || (kind == KIND_LOAD)) && !stall;
        st_d.stg[0].is_load = (kind == KIND_LOAD);
        st_d.stg[0].rd      = iss_rd_i;
        st_d.stg[0].data    = iss_data_i;
        if (!rst_ni) begin
            st_d      = '0;
            st_d.late = late_wb_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/wbs_checker.sv
module wbs_checker
    import wbs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              late,
    input logic [1:0]        kind,
    input logic [REG_AW-1:0] rd,
    input logic [DATA_W-1:0] data,
    input logic              stall,
    input logic              we,
    input logic [REG_AW-1:0] waddr,
    input logic [DATA_W-1:0] wdata,
    input logic              clash
);
    logic acc_ld, acc_alu;
    assign acc_ld  = rst_n && !stall && (kind == 2'b10) && (rd != '0);
    assign acc_alu = rst_n && !stall && (kind == 2'b01) && (rd != '0);

    p_load_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_ld, 4) |-> (we && waddr == $past(rd, 4) && wdata == $past(data, 4)));

    p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n) !clash);

    p_alu_early_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!late && $past(acc_alu, 3)) |-> (we && waddr == $past(rd, 3) && wdata == $past(data, 3)));

    p_stall_alu_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (kind == 2'b01));

    p_stall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    p_late_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        late |-> !stall);

    p_alu_late_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (late && $past(acc_alu, 4)) |-> (we && waddr == $past(rd, 4)));

    p_no_zero_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr != '0));

    p_policy_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(late));
endmodule

bind wb_port_sched wbs_checker u_chk (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .late  (st_q.late),
    .kind  (iss_kind_i),
    .rd    (iss_rd_i),
    .data  (iss_data_i),
    .stall (fetch_stall_o),
    .we    (rf_we_o),
    .waddr (rf_waddr_o),
    .wdata (rf_wdata_o),
    .clash (wb_clash)
);

// File: tb/wb_port_sched_tb.sv
module wb_port_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 20;

    // {kind[1:0], rd[4:0]}; kind 10 load, 01 ALU, 00 none, 11 reserved
    localparam logic [6:0] VEC [NVEC] = '{
        {2'b10, 5'd1},  {2'b01, 5'd2},  {2'b01, 5'd3},  {2'b00, 5'd0},
        {2'b10, 5'd4},  {2'b10, 5'd5},  {2'b01, 5'd6},  {2'b01, 5'd0},
        {2'b10, 5'd0},  {2'b11, 5'd7},  {2'b01, 5'd8},  {2'b10, 5'd9},
        {2'b01, 5'd10}, {2'b00, 5'd0},  {2'b01, 5'd11}, {2'b10, 5'd12},
        {2'b10, 5'd13}, {2'b01, 5'd14}, {2'b00, 5'd0},  {2'b01, 5'd15}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        late_wb = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic [4:0]  rd = '0;
    logic [31:0] data = '0;
    logic        stall, we;
    logic [4:0]  waddr;
    logic [31:0] wdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int seq = 0;
    int last_seq = -1;
    logic        model_late;
    logic        prev_load;
    logic        sw_v [16];
    logic [4:0]  sw_a [16];
    logic [31:0] sw_d [16];
    int          sw_s [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    wb_port_sched dut_i (
        .clk_i(clk), .rst_ni(rst_n), .late_wb_i(late_wb),
        .iss_kind_i(kind), .iss_rd_i(rd), .iss_data_i(data),
        .fetch_stall_o(stall), .rf_we_o(we), .rf_waddr_o(waddr), .rf_wdata_o(wdata)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic do_reset(input logic pol);
        rst_n = 1'b0;
        late_wb = pol;
        kind = 2'b00;
        for (int i = 0; i < 16; i++) sw_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: quiet during reset
        check(!we && !stall, "R9", {62'd0, we, stall}, 64'd0);
        rst_n = 1'b1;
        model_late = pol;
        prev_load = 1'b0;
        last_seq = -1;
        cyc = 0;
    endtask

    // One cycle: drive at negedge, check between edges, advance
    task automatic step(input logic [1:0] k, input logic [4:0] r, input logic [31:0] d, output bit accepted);
        bit exp_stall;
        int slot;
        int due;
        @(negedge clk);
        kind = k; rd = r; data = d;
        #1;
        exp_stall = !model_late && (k == 2'b01) && prev_load;
        // R4 / R5: stall only for an ALU right behind an accepted load, early policy only
        check(stall == exp_stall, model_late ? "R5" : "R4", {63'd0, stall}, {63'd0, exp_stall});
        slot = cyc % 16;
        // R1 / R3 / R6 / R9: write presence in its due cycle
        check(we == sw_v[slot], "R1", {63'd0, we}, {63'd0, sw_v[slot]});
        if (we && sw_v[slot]) begin
            check(waddr == sw_a[slot] && wdata == sw_d[slot], "R3",
                  {27'd0, waddr, wdata}, {27'd0, sw_a[slot], sw_d[slot]});
            // R8: acceptance order preserved
            check(sw_s[slot] > last_seq, "R8", 64'(sw_s[slot]), 64'(last_seq + 1));
            last_seq = sw_s[slot];
        end
        sw_v[slot] = 1'b0;
        accepted = !exp_stall && (k == 2'b01 || k == 2'b10);
        if (accepted) begin
            due = cyc + ((k == 2'b01 && !model_late) ? 3 : 4);
            if (r != 5'd0) begin
                // R2: model never books two writes in one cycle
                check(!sw_v[due % 16], "R2", 64'd1, 64'd0);
                sw_v[due % 16] = 1'b1;
                sw_a[due % 16] = r;
                sw_d[due % 16] = d;
                sw_s[due % 16] = seq;
            end
            seq++;
        end
        prev_load = accepted && (k == 2'b10);
        @(posedge clk);
        cyc++;
    endtask

    task automatic run_table(input logic pol_reset, input logic pol_after, input int pass);
        bit acc;
        do_reset(pol_reset);
        late_wb = pol_after;   // R7: later changes must not matter
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] d;
            d = 32'h5A00_0000 | (pass << 16) | i;
            step(VEC[i][6:5], VEC[i][4:0], d, acc);
            if (!acc && VEC[i][6:5] == 2'b01)
                step(VEC[i][6:5], VEC[i][4:0], d, acc);   // held after a stall (R4)
        end
        for (int i = 0; i < 6; i++) step(2'b00, 5'd0, 32'd0, acc);
    endtask

    initial begin
        bit acc;
        run_table(1'b0, 1'b1, 1);   // early policy, input flipped afterwards (R7)
        run_table(1'b1, 1'b0, 2);   // uniform policy, input flipped afterwards (R5, R7)
        // Directed: back-to-back load then ALU under early policy (R4)
        do_reset(1'b0);
        step(2'b10, 5'd20, 32'hAAAA_0001, acc);
        step(2'b01, 5'd21, 32'hAAAA_0002, acc);
        check(!acc, "R4", {63'd0, acc}, 64'd0);
        step(2'b01, 5'd21, 32'hAAAA_0002, acc);
        check(acc, "R4", {63'd0, acc}, 64'd1);
        // Directed: reserved kind and rd 0 produce nothing (R6, R9)
        step(2'b11, 5'd22, 32'hBBBB_0000, acc);
        step(2'b01, 5'd0, 32'hCCCC_0000, acc);
        for (int i = 0; i < 6; i++) step(2'b00, 5'd0, 32'd0, acc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule